// File: doc/BRIEF.md
# Bracket Loop Controller with Matching-Bracket Cache

This block computes the next program counter for the two loop instructions of a small stack-free-language processor: the loop opener and the loop closer. Each cycle in which the core presents an instruction (`step_i`), the block takes the opcode class, the address of that instruction and a flag saying whether the current data cell is zero. One cycle later it returns the address to fetch next, a flag saying the instruction was passed over as a no-op, and a sticky error flag.

Loop closers take constant time. The block keeps a stack of opener addresses, so a closer with a non-zero cell jumps straight back to the first body instruction. An opener with a zero cell has to skip its whole body. The first time that happens, the block steps over the body one instruction at a time. The same stack tracks nesting during that scan, and each closer it meets writes its partner opener's end address into a per-address cache. Later zero-cell visits to any opener inside that region then land past the matching closer in one step. This keeps the average cost per instruction location bounded as a program runs.

The opcode classes are `2'b00` for any other instruction, `2'b01` for the loop opener and `2'b10` for the loop closer. The value `2'b11` is treated as another instruction.

Top module: `bl_loop_ctrl`

## Requirements
- R1: While reset is held and after it is released, no result is reported, `err_o` is 0 and every entry of the matching-bracket cache is invalid. Reset is asserted asynchronously and released through two synchronizing flops.
- R2: Outside a scan and with no error, an instruction of class `2'b00` or `2'b11` at address P gives `res_pc_o` = P+1 with `res_skip_o` = 0 on the cycle after the step.
- R3: An opener (`2'b01`) at P with a non-zero cell pushes P and gives P+1.
- R4: A closer (`2'b10`) with a non-zero cell gives T+1, where T is the top of the stack, and leaves the stack unchanged.
- R5: A closer with a zero cell pops the stack and gives P+1.
- R6: An opener at P with a zero cell and no cache entry for P gives P+1 with `res_skip_o` = 0 and starts a scan. Every later step up to and including the matching closer gives P'+1 with `res_skip_o` = 1, whatever the cell flag. The scan ends when the nesting depth returns to zero.
- R7: During a scan, each closer records the address of that closer as the end of its matching opener. This covers the outer loop and every nested loop.
- R8: An opener at P with a zero cell and a valid cache entry E gives E+1 in a single step, with no push and no scan.
- R9: A push onto a full stack (depth `STACK_D`) sets `err_o`. The result for that step is the unchanged address P. `err_o` stays set until reset.
- R10: A closer met outside a scan with an empty stack sets `err_o`, and its result is the unchanged address P.
- R11: While `err_o` is set, every step gives `res_pc_o` = P with `res_skip_o` = 0 and changes neither the stack nor the cache.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | An instruction is presented this cycle |
| op_i | input | 2 | Opcode class: 00 other, 01 opener, 10 closer, 11 other |
| pc_i | input | PC_W | Address of the presented instruction |
| cell_zero_i | input | 1 | Current data cell is zero |
| res_valid_o | output | 1 | Result for the previous step is valid |
| res_pc_o | output | PC_W | Next address to fetch |
| res_skip_o | output | 1 | Instruction was passed over by a scan |
| err_o | output | 1 | Sticky stack overflow or underflow |

## Verification
A wrong stack top shows up on the very next closer with a non-zero cell, as a return address other than the opener's address plus one. A cache entry that is stale or was never written shows up on the next zero-cell visit to that opener. It appears either as a wrong jump target or as an unexpected scan, with `res_skip_o` rising on the following step. A nesting depth that is off by one ends the scan one closer early or late, so `res_skip_o` is wrong on the step right after the true match. A missed error shows within one step, as an address that advances when it should hold.

// File: rtl/bl_loop_pkg.sv
package bl_loop_pkg;
  typedef enum logic [1:0] {
    OPC_OTHER = 2'b00,
    OPC_OPEN  = 2'b01,
    OPC_CLOSE = 2'b10,
    OPC_ALT   = 2'b11
  } opc_e;
endpackage

// File: rtl/bl_stack.sv
module bl_stack #(
  parameter int W = 8,
  parameter int D = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] top_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int CW = $clog2(D + 1);
  localparam int AW = (D > 1) ? $clog2(D) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  mem_q [D];
  logic [CW-1:0] top_idx;

  always_comb begin
    cnt_d = cnt_q;
    if (push_i && !full_o)      cnt_d = cnt_q + 1'b1;
    else if (pop_i && !empty_o) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    if (push_i && !full_o) mem_q[cnt_q[AW-1:0]] <= din_i;
  end

  assign top_idx = cnt_q - 1'b1;
  assign top_o   = mem_q[top_idx[AW-1:0]];
  assign full_o  = (cnt_q == CW'(D));
  assign empty_o = (cnt_q == '0);
endmodule

// File: rtl/bl_index.sv
module bl_index #(
  parameter int PC_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] rd_addr_i,
  output logic            rd_valid_o,
  output logic [PC_W-1:0] rd_end_o,
  input  logic            wr_en_i,
  input  logic [PC_W-1:0] wr_addr_i,
  input  logic [PC_W-1:0] wr_end_i
);
  localparam int N = 1 << PC_W;

  logic [N-1:0]    vld_q;
  logic [PC_W-1:0] end_q [N];

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic hit;
    assign hit = wr_en_i && (wr_addr_i == PC_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   vld_q[g] <= 1'b0;
      else if (hit) vld_q[g] <= 1'b1;
    end
    always_ff @(posedge clk) begin
      if (hit) end_q[g] <= wr_end_i;
    end
  end

  assign rd_valid_o = vld_q[rd_addr_i];
  assign rd_end_o   = end_q[rd_addr_i];
endmodule

// File: rtl/bl_loop_ctrl.sv
module bl_loop_ctrl #(
  parameter int PC_W    = 8,
  parameter int STACK_D = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step_i,
  input  logic [1:0]      op_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic            cell_zero_i,
  output logic            res_valid_o,
  output logic [PC_W-1:0] res_pc_o,
  output logic            res_skip_o,
  output logic            err_o
);
  import bl_loop_pkg::*;
  localparam int DW = $clog2(STACK_D + 1);

  logic rst_m_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_m_q    <= 1'b1;
      rst_sync_n <= rst_m_q;
    end
  end

  opc_e op;
  assign op = opc_e'(op_i);

  logic            push, pop, full, empty;
  logic [PC_W-1:0] top;
  logic            idx_vld, idx_we;
  logic [PC_W-1:0] idx_end;

  bl_stack #(.W(PC_W), .D(STACK_D)) stack_i (
    .clk(clk), .rst_n(rst_sync_n), .push_i(push), .pop_i(pop),
    .din_i(pc_i), .top_o(top), .full_o(full), .empty_o(empty)
  );

  bl_index #(.PC_W(PC_W)) index_i (
    .clk(clk), .rst_n(rst_sync_n), .rd_addr_i(pc_i), .rd_valid_o(idx_vld),
    .rd_end_o(idx_end), .wr_en_i(idx_we), .wr_addr_i(top), .wr_end_i(pc_i)
  );

  logic            scan_q, scan_d;
  logic [DW-1:0]   depth_q, depth_d;
  logic            err_q, err_d;
  logic            rv_q;
  logic [PC_W-1:0] rpc_q, rpc_d;
  logic            rskip_q, rskip_d;
  logic [PC_W-1:0] pc_inc;

  assign pc_inc = pc_i + 1'b1;

  always_comb begin
    push    = 1'b0;
    pop     = 1'b0;
    idx_we  = 1'b0;
    scan_d  = scan_q;
    depth_d = depth_q;
    err_d   = err_q;
    rpc_d   = rpc_q;
    rskip_d = rskip_q;
    if (step_i) begin
      rpc_d   = pc_inc;
      rskip_d = 1'b0;
      if (err_q) begin
        rpc_d = pc_i;
      end else if (scan_q) begin
        rskip_d = 1'b1;
        unique case (op)
          OPC_OPEN: begin
            if (full) begin
              err_d   = 1'b1;
              rpc_d   = pc_i;
              rskip_d = 1'b0;
            end else begin
              push    = 1'b1;
              depth_d = depth_q + 1'b1;
            end
          end
          OPC_CLOSE: begin
            if (empty) begin
              err_d   = 1'b1;
              rpc_d   = pc_i;
              rskip_d = 1'b0;
            end else begin
              pop     = 1'b1;
              idx_we  = 1'b1;
              depth_d = depth_q - 1'b1;
              if (depth_q == DW'(1)) scan_d = 1'b0;
            end
          end
          default: ;
        endcase
      end else begin
        unique case (op)
          OPC_OPEN: begin
            if (cell_zero_i && idx_vld) begin
              rpc_d = idx_end + 1'b1;
            end else if (full) begin
              err_d = 1'b1;
              rpc_d = pc_i;
            end else begin
              push = 1'b1;
              if (cell_zero_i) begin
                scan_d  = 1'b1;
                depth_d = DW'(1);
              end
            end
          end
          OPC_CLOSE: begin
            if (empty) begin
              err_d = 1'b1;
              rpc_d = pc_i;
            end else if (cell_zero_i) begin
              pop = 1'b1;
            end else begin
              rpc_d = top + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      scan_q  <= 1'b0;
      depth_q <= '0;
      err_q   <= 1'b0;
      rv_q    <= 1'b0;
      rpc_q   <= '0;
      rskip_q <= 1'b0;
    end else begin
      scan_q  <= scan_d;
      depth_q <= depth_d;
      err_q   <= err_d;
      rv_q    <= step_i;
      if (step_i) begin
        rpc_q   <= rpc_d;
        rskip_q <= rskip_d;
      end
    end
  end

  assign res_valid_o = rv_q;
  assign res_pc_o    = rpc_q;
  assign res_skip_o  = rskip_q;
  assign err_o       = err_q;
endmodule

// File: rtl/bl_loop_ctrl_chk.sv
module bl_loop_ctrl_chk #(
  parameter int PC_W = 8
) (
  input logic            clk,
  input logic            rst_sync_n,
  input logic            step_i,
  input logic [1:0]      op_i,
  input logic [PC_W-1:0] pc_i,
  input logic            scan_q,
  input logic            res_valid_o,
  input logic [PC_W-1:0] res_pc_o,
  input logic            res_skip_o,
  input logic            err_o
);
  assert_result_needs_step_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    res_valid_o |-> $past(step_i));

  assert_plain_advance_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (step_i && !err_o && !scan_q && !op_i[0] && !op_i[1]) |=>
      (res_pc_o == PC_W'($past(pc_i) + 1'b1) && !res_skip_o));

  assert_scan_marks_skip_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (step_i && !err_o && scan_q && !(op_i == 2'b01)) |=> res_skip_o);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    err_o |=> err_o);

  assert_hold_on_err_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (step_i && err_o) |=> (res_pc_o == $past(pc_i) && !res_skip_o));
endmodule

bind bl_loop_ctrl bl_loop_ctrl_chk #(.PC_W(PC_W)) chk_i (
  .clk(clk), .rst_sync_n(rst_sync_n), .step_i(step_i), .op_i(op_i), .pc_i(pc_i),
  .scan_q(scan_q), .res_valid_o(res_valid_o), .res_pc_o(res_pc_o),
  .res_skip_o(res_skip_o), .err_o(err_o)
);

// File: tb/bl_loop_ctrl_tb_top.sv
module bl_loop_ctrl_tb_top;
  localparam int PC_W = 8;
  localparam logic [1:0] OT = 2'b00, OP = 2'b01, CL = 2'b10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step = 1'b0;
  logic [1:0] op = 2'b00;
  logic [PC_W-1:0] pc = '0;
  logic cz = 1'b0;
  logic rv, rskip, err;
  logic [PC_W-1:0] rpc;

  always #2.5 clk = ~clk;

  bl_loop_ctrl #(.PC_W(PC_W), .STACK_D(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .step_i(step), .op_i(op), .pc_i(pc),
    .cell_zero_i(cz), .res_valid_o(rv), .res_pc_o(rpc), .res_skip_o(rskip),
    .err_o(err)
  );

  typedef struct {
    logic [PC_W-1:0] pc;
    logic skip;
    logic err;
    string tag;
  } exp_t;

  exp_t q[$];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input string msg);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  task automatic drive(input logic [1:0] o, input int p, input bit z,
                       input int epc, input bit esk, input bit eer, input string tag);
    exp_t e;
    @(negedge clk);
    step = 1'b1; op = o; pc = PC_W'(p); cz = z;
    e.pc = PC_W'(epc); e.skip = esk; e.err = eer; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    step = 1'b0;
  endtask

  always begin
    @(posedge clk); #1;
    if (rv) begin
      if (q.size() == 0) chk(1'b0, "R1", "result with nothing expected");
      else begin
        exp_t e;
        e = q.pop_front();
        chk(rpc == e.pc && rskip == e.skip && err == e.err, e.tag,
            $sformatf("pc/skip/err got %0d/%0b/%0b exp %0d/%0b/%0b",
                      rpc, rskip, err, e.pc, e.skip, e.err));
      end
    end
  end

  initial begin
    #(5 * 20000);
    chk(1'b0, "WDOG", "watchdog expired got running exp finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!rv && !err, "R1", $sformatf("in reset got rv=%0b err=%0b exp 0/0", rv, err));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!rv && !err, "R1", $sformatf("after reset got rv=%0b err=%0b exp 0/0", rv, err));

    drive(OT, 0, 0, 1, 0, 0, "R2");
    drive(2'b11, 1, 1, 2, 0, 0, "R2");
    // first zero-cell opener: scan over nested body
    drive(OP, 2, 1, 3, 0, 0, "R6");
    drive(OT, 3, 0, 4, 1, 0, "R6");
    drive(OP, 4, 0, 5, 1, 0, "R6");
    drive(OT, 5, 1, 6, 1, 0, "R6");
    drive(CL, 6, 0, 7, 1, 0, "R7");
    drive(CL, 7, 0, 8, 1, 0, "R7");
    drive(OT, 8, 0, 9, 0, 0, "R6");
    // cached jumps, outer and nested
    drive(OP, 2, 1, 8, 0, 0, "R8");
    drive(OP, 4, 1, 7, 0, 0, "R8");
    // normal looping
    drive(OP, 2, 0, 3, 0, 0, "R3");
    drive(CL, 7, 0, 3, 0, 0, "R4");
    drive(CL, 7, 1, 8, 0, 0, "R5");
    drive(OP, 10, 0, 11, 0, 0, "R3");
    drive(OP, 12, 0, 13, 0, 0, "R3");
    drive(CL, 14, 0, 13, 0, 0, "R4");
    drive(CL, 14, 1, 15, 0, 0, "R5");
    drive(CL, 16, 0, 11, 0, 0, "R4");
    drive(CL, 16, 1, 17, 0, 0, "R5");
    // overflow
    for (int i = 0; i < 8; i++) drive(OP, 20 + i, 0, 21 + i, 0, 0, "R3");
    drive(OP, 28, 0, 28, 0, 1, "R9");
    drive(OT, 29, 0, 29, 0, 1, "R11");
    drive(CL, 30, 1, 30, 0, 1, "R11");
    // reset clears cache and error
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(!err, "R1", $sformatf("err after reset got %0b exp 0", err));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    drive(OP, 2, 1, 3, 0, 0, "R1");
    drive(CL, 3, 1, 4, 1, 0, "R6");
    drive(OT, 4, 0, 5, 0, 0, "R2");
    // underflow
    drive(CL, 40, 0, 40, 0, 1, "R10");
    drive(OT, 41, 0, 41, 0, 1, "R11");
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R1", $sformatf("pending results got %0d exp 0", q.size()));
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule